// File: doc/BRIEF.md
# Correlated Double Sampling Result Formatter

This block takes the two averaged data points of one integration cycle of a 20-bit integrating converter: the point taken just after the integrator reset and the point taken at the end of integration. It subtracts the first from the second. That cancels errors which repeat in every cycle, such as reset-switch charge injection, reset noise and comparator offset. Because the difference is recomputed for every pair, the correction tracks drift in time and temperature. The subtraction can be switched off, and then the end-of-integration point is passed through alone.

The result is limited to the charge range in use and then emitted as two's complement or as offset (straight) binary. In the unipolar range the result runs from full scale down to a small negative overrange of 1/256 of full scale. In the bipolar range the negative limit exceeds the positive limit by that same overrange. Offset binary cannot carry a bipolar difference, so that combination is replaced by two's complement and flagged.

Pairs enter on a valid/ready stream and results leave on another. A pair is taken on a rising clock edge with `in_valid` and `in_ready` both high. The result is then held on the output, with `out_valid` high, until a rising edge with `out_ready` high. `in_ready` is low only while a result is waiting and `out_ready` is low. The mode pins are sampled together with the pair.

Top module: `cds_formatter`

## Requirements
- R1: With `cds_en`=1, the result is `in_last` minus `in_first`, both read as 20-bit two's complement and subtracted at 21 bits, so it never wraps.
- R2: With `cds_en`=0, the result is `in_last` alone, limited as in R3/R4.
- R3: With `range_bip`=0 (unipolar), the result is saturated to the interval [-2048, +524287].
- R4: With `range_bip`=1 (bipolar), the result is saturated to the interval [-264191, +262143].
- R5: With `fmt_offset`=0, `out_data` is the saturated result in 20-bit two's complement.
- R6: With offset binary in effect, `out_data` is the saturated result with bit 19 inverted, so zero appears as 0x80000. Offset binary is in effect when `fmt_offset`=1 and either `range_bip`=0 or `cds_en`=0.
- R7: With `cds_en`=1, `range_bip`=1 and `fmt_offset`=1, the output is forced to two's complement and `cfg_err`=1. For every other setting `cfg_err`=0. `cfg_err` belongs to the result it is presented with.
- R8: `out_valid` is high in the cycle after the edge that takes a pair. With `out_ready` high it stays high for exactly one clock, unless a new pair is taken at that edge.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready`=0 and `out_data` and `cfg_err` stay unchanged.
- R10: While `rst_n`=0, `out_valid`=0, `out_data`=0, `cfg_err`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data-point pair is offered |
| in_ready | output | 1 | The block can take a pair this cycle |
| in_first | input | 20 | Point taken after the integrator reset, two's complement |
| in_last | input | 20 | Point taken at the end of integration, two's complement |
| cds_en | input | 1 | 1 = subtract `in_first`, 0 = pass `in_last` |
| range_bip | input | 1 | 0 = unipolar limits, 1 = bipolar limits |
| fmt_offset | input | 1 | 0 = two's complement, 1 = offset binary |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 20 | Formatted result |
| cfg_err | output | 1 | The mode setting of this result was illegal and was overridden |

## Verification
Assertions check the stream rules on every clock. A taken pair must lead to a valid result. A consumed result must disappear unless it is replaced. A held result must not change while the input is blocked. The illegal-setting flag must follow the sampled mode pins. The saturated difference must also lie inside the limits of the selected range. Only the bench scenarios show the actual numbers: the exact differences, the saturation points on both sides of each range, the wrap-free subtraction at the extreme codes, the offset-binary mapping of zero and negative values, and the forced format in the illegal bipolar case.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic {FMT_TWOS = 1'b0, FMT_OFFSET = 1'b1} fmt_e;
  typedef enum logic {RNG_UNI = 1'b0, RNG_BIP = 1'b1} rng_e;
endpackage

// File: rtl/cds_diff.sv
module cds_diff #(
  parameter int DW = 20,
  localparam int W = DW + 1
) (
  input  logic signed [DW-1:0] first_i,
  input  logic signed [DW-1:0] last_i,
  input  logic                 sub_en_i,
  output logic signed [W-1:0]  diff_o
);
  logic signed [W-1:0] ext_first;
  logic signed [W-1:0] ext_last;

  // one extra bit of headroom so that full-scale minus full-scale cannot wrap
  assign ext_first = {first_i[DW-1], first_i};
  assign ext_last  = {last_i[DW-1], last_i};

  always_comb begin
    if (sub_en_i) diff_o = ext_last - ext_first;
    else          diff_o = ext_last;
  end
endmodule

// File: rtl/cds_clamp.sv
module cds_clamp #(
  parameter int DW = 20,
  parameter int OVR_SHIFT = 8,
  localparam int W = DW + 1
) (
  input  logic signed [W-1:0]  val_i,
  input  cds_pkg::rng_e        rng_i,
  output logic signed [DW-1:0] val_o
);
  import cds_pkg::*;

  localparam longint UHI_L = (longint'(1) << (DW - 1)) - 1;
  localparam longint OVR_L = (longint'(1) << (DW - 1)) >> OVR_SHIFT;
  localparam longint ULO_L = -OVR_L;
  localparam longint BHI_L = UHI_L / 2;
  localparam longint BLO_L = -(BHI_L + OVR_L);

  localparam logic signed [W-1:0] UHI = W'(UHI_L);
  localparam logic signed [W-1:0] ULO = W'(ULO_L);
  localparam logic signed [W-1:0] BHI = W'(BHI_L);
  localparam logic signed [W-1:0] BLO = W'(BLO_L);

  logic signed [W-1:0] hi;
  logic signed [W-1:0] lo;
  logic signed [W-1:0] sat;

  always_comb begin
    hi = (rng_i == RNG_BIP) ? BHI : UHI;
    lo = (rng_i == RNG_BIP) ? BLO : ULO;
    if (val_i > hi)      sat = hi;
    else if (val_i < lo) sat = lo;
    else                 sat = val_i;
  end

  assign val_o = sat[DW-1:0];

  // R3 and R4: the narrowed word, read back at full width, lies inside the selected range
  always_comb begin
    if (!$isunknown({val_i, rng_i})) begin
      a_r4_in_limits: assert ((W'(val_o) <= hi) && (W'(val_o) >= lo))
        else $error("saturated result outside range limits");
    end
  end
endmodule

// File: rtl/cds_fmt.sv
module cds_fmt #(
  parameter int DW = 20
) (
  input  logic signed [DW-1:0] val_i,
  input  logic                 sub_en_i,
  input  cds_pkg::rng_e        rng_i,
  input  cds_pkg::fmt_e        fmt_i,
  output logic [DW-1:0]        data_o,
  output logic                 err_o
);
  import cds_pkg::*;

  logic offset_act;

  // bipolar differences need a sign; offset binary is overridden there
  assign err_o      = sub_en_i && (rng_i == RNG_BIP) && (fmt_i == FMT_OFFSET);
  assign offset_act = (fmt_i == FMT_OFFSET) && !err_o;

  always_comb begin
    if (offset_act) data_o = {~val_i[DW-1], val_i[DW-2:0]};
    else            data_o = val_i;
  end
endmodule

// File: rtl/cds_formatter.sv
module cds_formatter #(
  parameter int DW = 20,
  parameter int OVR_SHIFT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_first,
  input  logic [DW-1:0] in_last,
  input  logic          cds_en,
  input  logic          range_bip,
  input  logic          fmt_offset,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          cfg_err
);
  import cds_pkg::*;

  localparam int W = DW + 1;

  logic                 accept;
  logic signed [W-1:0]  diff;
  logic signed [DW-1:0] sat;
  logic [DW-1:0]        fmt_data;
  logic                 fmt_err;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cds_diff #(.DW(DW)) u_diff (
    .first_i  (in_first),
    .last_i   (in_last),
    .sub_en_i (cds_en),
    .diff_o   (diff)
  );

  cds_clamp #(.DW(DW), .OVR_SHIFT(OVR_SHIFT)) u_clamp (
    .val_i (diff),
    .rng_i (rng_e'(range_bip)),
    .val_o (sat)
  );

  cds_fmt #(.DW(DW)) u_fmt (
    .val_i    (sat),
    .sub_en_i (cds_en),
    .rng_i    (rng_e'(range_bip)),
    .fmt_i    (fmt_e'(fmt_offset)),
    .data_o   (fmt_data),
    .err_o    (fmt_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      cfg_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= fmt_data;
      cfg_err   <= fmt_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r8_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !accept) |=> !out_valid);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(cfg_err)));

  a_r9_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cds_en && range_bip && fmt_offset) |=> cfg_err);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(cds_en && range_bip && fmt_offset)) |=> !cfg_err);
endmodule

// File: tb/test_cds_formatter.sv
module test_cds_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_first = '0;
  logic [19:0] in_last = '0;
  logic        cds_en = 1'b0;
  logic        range_bip = 1'b0;
  logic        fmt_offset = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_data;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cds_formatter i_cds_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .cds_en(cds_en),
    .range_bip(range_bip), .fmt_offset(fmt_offset), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cfg_err(cfg_err)
  );

  // layout: req[67:64] cds[63] bip[62] off[61] err[60] first[59:40] last[39:20] expected[19:0]
  localparam int NV = 15;
  localparam logic [67:0] VEC [NV] = '{
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 20'h00064, 20'h0044C, 20'h003E8}, // R1 plain difference
    {4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 20'h00064, 20'h0044C, 20'h803E8}, // R6 offset binary
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 20'h00064, 20'h0044C, 20'h0044C}, // R2 pass-through
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 20'h7FFFF, 20'h80000, 20'hFF800}, // R3 low clamp, no wrap
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 20'h80000, 20'h7FFFF, 20'h7FFFF}, // R3 high clamp, no wrap
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 20'h0000A, 20'h00008, 20'hFFFFE}, // R3 small negative kept
    {4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 20'h0000A, 20'h00008, 20'h7FFFE}, // R6 negative offset code
    {4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 20'h00005, 20'h00005, 20'h80000}, // R6 zero maps to 0x80000
    {4'd4,  1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h7FFFF, 20'h3FFFF}, // R4 bipolar high clamp
    {4'd4,  1'b1, 1'b1, 1'b0, 1'b0, 20'h7FFFF, 20'h80000, 20'hBF801}, // R4 bipolar low clamp
    {4'd7,  1'b1, 1'b1, 1'b1, 1'b1, 20'h00000, 20'h80000, 20'hBF801}, // R7 forced two's complement
    {4'd6,  1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 20'h00010, 20'h80010}, // R6 bipolar offset, no CDS
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 20'h12345, 20'hFFFF0, 20'hFFFF0}, // R2 first point ignored
    {4'd5,  1'b1, 1'b1, 1'b0, 1'b0, 20'h00100, 20'hFFF00, 20'hFFE00}, // R5 negative two's complement
    {4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h50000, 20'h3FFFF}  // R4 clamp without CDS
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic b, input logic o,
                       input logic [19:0] f, input logic [19:0] l);
    cds_en = c; range_bip = b; fmt_offset = o;
    in_first = f; in_last = l; in_valid = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 out_valid", {19'b0, out_valid}, 20'h0);
    chk("R10 out_data", out_data, 20'h0);
    chk("R10 cfg_err", {19'b0, cfg_err}, 20'h0);
    chk("R10 in_ready", {19'b0, in_ready}, 20'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][63], VEC[i][62], VEC[i][61], VEC[i][59:40], VEC[i][39:20]);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 valid vec%0d", i), {19'b0, out_valid}, 20'h1);
      chk($sformatf("R%0d data vec%0d", VEC[i][67:64], i), out_data, VEC[i][19:0]);
      chk($sformatf("R7 flag vec%0d", i), {19'b0, cfg_err}, {19'b0, VEC[i][60]});
      @(negedge clk);
      chk($sformatf("R8 single pulse vec%0d", i), {19'b0, out_valid}, 20'h0);
    end

    // R9 back-pressure: first result held, second pair waits
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 20'h00000, 20'h00007);
    @(negedge clk);
    chk("R9 held valid", {19'b0, out_valid}, 20'h1);
    chk("R9 held data", out_data, 20'h00007);
    chk("R9 input blocked", {19'b0, in_ready}, 20'h0);
    drive(1'b0, 1'b0, 1'b1, 20'h00000, 20'h00003);
    repeat (2) @(negedge clk);
    chk("R9 data unchanged", out_data, 20'h00007);
    chk("R9 still valid", {19'b0, out_valid}, 20'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result valid", {19'b0, out_valid}, 20'h1);
    chk("R9 second result data", out_data, 20'h80003);
    @(negedge clk);
    chk("R8 drained", {19'b0, out_valid}, 20'h0);

    // R10 reset while a result is waiting
    out_ready = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 20'h00000, 20'h00001);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 valid cleared", {19'b0, out_valid}, 20'h0);
    chk("R10 data cleared", out_data, 20'h0);
    chk("R10 flag cleared", {19'b0, cfg_err}, 20'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule